// File: doc/BRIEF.md
# Alarm-Driven Gate Clamp Controller

This block decides, for each output channel of a bias controller, whether the gate drive of that channel is forced to ground. Each channel has a 2-bit clamp mode written by the host. It also receives the result of periodic conversions for the channel: a done strobe that qualifies an alarm-tripped flag. From these it produces a clamp output, a sticky alarm flag, and a readback of the mode bits. The hardware itself may rewrite the mode readback.

A mode has four values:

- **Report only**: alarms are flagged and the gate is never clamped.
- **Forced**: the gate is clamped at once, whatever the alarms.
- **Auto**: the clamp follows the latest conversion, so an alarm clamps the gate and a clean conversion releases it.
- **Latching**: the first alarm clamps the gate and the hardware rewrites the mode to forced. Only a fresh host write of the latching mode re-arms the channel.

Each channel is one Moore state machine with five named states:

- `ST_REPORT` (mode 00, released)
- `ST_FORCED` (mode 01, clamped)
- `ST_AUTO_ARMED` (mode 10, released)
- `ST_AUTO_TRIPPED` (mode 10, clamped)
- `ST_LATCH_ARMED` (mode 11, released)

The transitions are as follows:

- Host write `T_WRITE`: from any state to the state of the written mode.
- Trip in auto mode `T_AUTO_TRIP`: `ST_AUTO_ARMED` to `ST_AUTO_TRIPPED` on an alarm conversion.
- Release in auto mode `T_AUTO_CLEAR`: `ST_AUTO_TRIPPED` to `ST_AUTO_ARMED` on a clean conversion.
- Latch `T_LATCH_TRIP`: `ST_LATCH_ARMED` to `ST_FORCED` on an alarm conversion.

Every other case holds the current state. A separate flag register per channel keeps the alarm flag. The top module instantiates one state machine and one flag per channel; there are two channels by default.

Top module: `gate_clamp_ctrl`

## Requirements
- R1: After reset every channel reads mode 00, has the clamp low and has the alarm flag low.
- R2: In mode 00, an alarm conversion sets the alarm flag in the next cycle and the clamp stays low.
- R3: In mode 01, the clamp is high from the cycle after the write, and conversions with or without an alarm do not release it.
- R4: In mode 10, a conversion with the alarm set raises the clamp in the next cycle, and the mode reads 10.
- R5: In mode 10, a conversion with the alarm clear drops the clamp in the next cycle.
- R6: In mode 11, a conversion with the alarm set raises the clamp in the next cycle and changes the mode readback from 11 to 01. The clamp then stays high through later clean conversions.
- R7: A host write of 11 to a channel whose clamp was latched releases the clamp in the next cycle, and the mode then reads 11.
- R8: The alarm flag is set by any alarm conversion in every mode and cleared only by the clear strobe. When a set and a clear occur in the same cycle, the set wins.
- R9: When the done strobe is low, the alarm input has no effect on the clamp, the mode or the flag.
- R10: When a host write and a conversion-driven state change fall in the same cycle, the host write wins. The mode reads the written value and the clamp follows the written mode's released state (or the clamped state for 01).
- R11: A host write of any value is seen on the mode readback in the next cycle, with the clamp high only for 01.
- R12: Channels are independent: the inputs of one channel never change the outputs of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_wr_en | input | NUM_CH | Per-channel host mode write strobe |
| mode_wr_data | input | 2*NUM_CH | Mode written to channel i is bits [2i+1:2i] |
| conv_done | input | NUM_CH | Per-channel conversion-done strobe |
| conv_alarm | input | NUM_CH | Per-channel alarm result, valid with conv_done |
| alarm_clr | input | NUM_CH | Per-channel clear strobe for the alarm flag |
| clamp | output | NUM_CH | High forces that channel's gate to ground |
| alarm_flag | output | NUM_CH | Sticky per-channel alarm flag |
| mode_rd | output | 2*NUM_CH | Current mode of channel i at bits [2i+1:2i] |

## Verification
A wrong state in a channel's machine shows on the clamp or on the mode readback in the very cycle after the edge that caused it. Each state maps to a distinct pair of those two outputs, so a state that has been entered or left wrongly cannot hide behind a matching output. A lost or spurious flag event stays visible on the flag until the next clear strobe. The bench therefore compares all three outputs of both channels against a behavioural model on every clock. Mismatches are caught at the first cycle they occur.

// File: rtl/gcc_pkg.sv
package gcc_pkg;

    localparam int MODE_W = 2;

    localparam logic [MODE_W-1:0] MODE_REPORT = 2'b00;
    localparam logic [MODE_W-1:0] MODE_FORCE  = 2'b01;
    localparam logic [MODE_W-1:0] MODE_AUTO   = 2'b10;
    localparam logic [MODE_W-1:0] MODE_LATCH  = 2'b11;

    typedef enum logic [2:0] {
        ST_REPORT       = 3'd0,
        ST_FORCED       = 3'd1,
        ST_AUTO_ARMED   = 3'd2,
        ST_AUTO_TRIPPED = 3'd3,
        ST_LATCH_ARMED  = 3'd4
    } clamp_state_e;

    // Entry state for a host-written mode (transition T_WRITE).
    function automatic clamp_state_e entry_state(input logic [MODE_W-1:0] m);
        clamp_state_e s;
        unique case (m)
            MODE_REPORT: s = ST_REPORT;
            MODE_FORCE:  s = ST_FORCED;
            MODE_AUTO:   s = ST_AUTO_ARMED;
            default:     s = ST_LATCH_ARMED;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/gcc_alarm_flag.sv
module gcc_alarm_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_evt,
    input  logic clr_evt,
    output logic flag
);

    logic flag_q;

    // Set has priority over clear so no alarm event is ever lost.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (clr_evt) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

    // R8: a set event is visible next cycle, even against a clear
    p_flag_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag);

    // R8: without a set or clear the flag holds
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!set_evt && !clr_evt) |=> $stable(flag));

    // R8: a clear alone drops the flag
    p_flag_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_evt && !set_evt) |=> !flag);

endmodule

// File: rtl/gcc_clamp_fsm.sv
module gcc_clamp_fsm
    import gcc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_mode,
    input  logic              conv_done,
    input  logic              conv_alarm,
    output logic              clamp,
    output logic [MODE_W-1:0] mode_rd
);

    clamp_state_e state_q;
    clamp_state_e state_d;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_REPORT;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state: host write first, then conversion-driven moves.
    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            state_d = entry_state(wr_mode);                       // T_WRITE
        end else if (conv_done) begin
            unique case (state_q)
                ST_REPORT:       state_d = ST_REPORT;
                ST_FORCED:       state_d = ST_FORCED;
                ST_AUTO_ARMED:   state_d = conv_alarm ? ST_AUTO_TRIPPED : ST_AUTO_ARMED; // T_AUTO_TRIP
                ST_AUTO_TRIPPED: state_d = conv_alarm ? ST_AUTO_TRIPPED : ST_AUTO_ARMED; // T_AUTO_CLEAR
                ST_LATCH_ARMED:  state_d = conv_alarm ? ST_FORCED : ST_LATCH_ARMED;      // T_LATCH_TRIP
                default:         state_d = ST_REPORT;
            endcase
        end
    end

    // Moore outputs
    always_comb begin
        unique case (state_q)
            ST_REPORT:       begin clamp = 1'b0; mode_rd = MODE_REPORT; end
            ST_FORCED:       begin clamp = 1'b1; mode_rd = MODE_FORCE;  end
            ST_AUTO_ARMED:   begin clamp = 1'b0; mode_rd = MODE_AUTO;   end
            ST_AUTO_TRIPPED: begin clamp = 1'b1; mode_rd = MODE_AUTO;   end
            ST_LATCH_ARMED:  begin clamp = 1'b0; mode_rd = MODE_LATCH;  end
            default:         begin clamp = 1'b0; mode_rd = MODE_REPORT; end
        endcase
    end

    // R2: report mode never clamps
    p_report_noclamp_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == MODE_REPORT) |-> !clamp);

    // R3: forced mode always clamps
    p_forced_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_rd == MODE_FORCE) |-> clamp);

    // R4: alarm in auto mode clamps next cycle
    p_auto_trip_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && conv_done && conv_alarm && mode_rd == MODE_AUTO)
        |=> (clamp && mode_rd == MODE_AUTO));

    // R5: clean conversion in auto mode releases next cycle
    p_auto_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && conv_done && !conv_alarm && mode_rd == MODE_AUTO)
        |=> (!clamp && mode_rd == MODE_AUTO));

    // R6: alarm in latching mode clamps and rewrites mode to 01
    p_latch_trip_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && conv_done && conv_alarm && mode_rd == MODE_LATCH)
        |=> (clamp && mode_rd == MODE_FORCE));

    // R10 / R11: a host write is always what is read back next
    p_host_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mode_rd == $past(wr_mode) && clamp == ($past(wr_mode) == MODE_FORCE)));

    // R9: without write or done strobe nothing moves
    p_idle_stable_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !conv_done) |=> ($stable(mode_rd) && $stable(clamp)));

endmodule

// File: rtl/gate_clamp_ctrl.sv
module gate_clamp_ctrl
    import gcc_pkg::*;
#(
    parameter int NUM_CH = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [NUM_CH-1:0]        mode_wr_en,
    input  logic [MODE_W*NUM_CH-1:0] mode_wr_data,
    input  logic [NUM_CH-1:0]        conv_done,
    input  logic [NUM_CH-1:0]        conv_alarm,
    input  logic [NUM_CH-1:0]        alarm_clr,
    output logic [NUM_CH-1:0]        clamp,
    output logic [NUM_CH-1:0]        alarm_flag,
    output logic [MODE_W*NUM_CH-1:0] mode_rd
);

    localparam int RD_W = MODE_W * NUM_CH;

    logic [NUM_CH-1:0] alarm_evt;
    logic [RD_W-1:0]   mode_rd_int;

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        // Alarm results count only when qualified by the done strobe.
        assign alarm_evt[ch] = conv_done[ch] & conv_alarm[ch];

        gcc_clamp_fsm u_fsm (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_en      (mode_wr_en[ch]),
            .wr_mode    (mode_wr_data[MODE_W*ch +: MODE_W]),
            .conv_done  (conv_done[ch]),
            .conv_alarm (conv_alarm[ch]),
            .clamp      (clamp[ch]),
            .mode_rd    (mode_rd_int[MODE_W*ch +: MODE_W])
        );

        gcc_alarm_flag u_flag (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_evt (alarm_evt[ch]),
            .clr_evt (alarm_clr[ch]),
            .flag    (alarm_flag[ch])
        );
    end

    assign mode_rd = mode_rd_int;

    // R1: state straight after reset release
    p_reset_state_r1: assert property (@(posedge clk)
        $rose(rst_n) |-> (clamp == '0 && alarm_flag == '0 && mode_rd == '0));

endmodule

// File: tb/gate_clamp_ctrl_bench.sv
module gate_clamp_ctrl_bench;

    localparam int NUM_CH = 2;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [NUM_CH-1:0]   mode_wr_en = '0;
    logic [2*NUM_CH-1:0] mode_wr_data = '0;
    logic [NUM_CH-1:0]   conv_done = '0;
    logic [NUM_CH-1:0]   conv_alarm = '0;
    logic [NUM_CH-1:0]   alarm_clr = '0;
    logic [NUM_CH-1:0]   clamp;
    logic [NUM_CH-1:0]   alarm_flag;
    logic [2*NUM_CH-1:0] mode_rd;

    int total = 0;
    int bad = 0;
    bit done_flag = 0;
    string cur_tag = "R1";

    // behavioural reference
    int m_mode [NUM_CH];
    int m_clamp[NUM_CH];
    int m_flag [NUM_CH];

    always #2.5 clk = ~clk;

    gate_clamp_ctrl #(.NUM_CH(NUM_CH)) u_gate_clamp_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_wr_en   (mode_wr_en),
        .mode_wr_data (mode_wr_data),
        .conv_done    (conv_done),
        .conv_alarm   (conv_alarm),
        .alarm_clr    (alarm_clr),
        .clamp        (clamp),
        .alarm_flag   (alarm_flag),
        .mode_rd      (mode_rd)
    );

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_CH; c++) begin
                m_mode[c] = 0; m_clamp[c] = 0; m_flag[c] = 0;
            end
        end else begin
            for (int c = 0; c < NUM_CH; c++) begin
                if (conv_done[c] && conv_alarm[c]) m_flag[c] = 1;
                else if (alarm_clr[c]) m_flag[c] = 0;
                if (mode_wr_en[c]) begin
                    m_mode[c]  = int'(mode_wr_data[2*c +: 2]);
                    m_clamp[c] = (m_mode[c] == 1) ? 1 : 0;
                end else if (conv_done[c]) begin
                    if (m_mode[c] == 2) m_clamp[c] = conv_alarm[c] ? 1 : 0;
                    else if (m_mode[c] == 3 && conv_alarm[c]) begin
                        m_mode[c] = 1; m_clamp[c] = 1;
                    end
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!done_flag) begin
            for (int c = 0; c < NUM_CH; c++) begin
                total++;
                if (int'(clamp[c]) != m_clamp[c] || int'(alarm_flag[c]) != m_flag[c]
                    || int'(mode_rd[2*c +: 2]) != m_mode[c]) begin
                    bad++;
                    $display("FAIL %s ch%0d clamp=%0d flag=%0d mode=%0d expected clamp=%0d flag=%0d mode=%0d",
                             cur_tag, c, clamp[c], alarm_flag[c], mode_rd[2*c +: 2],
                             m_clamp[c], m_flag[c], m_mode[c]);
                end
            end
        end
    end

    // one cycle of stimulus for channel 0, channel 1 idle
    task automatic cyc0(input bit wr, input bit [1:0] d, input bit dn, input bit al, input bit cl);
        @(negedge clk);
        mode_wr_en   = {1'b0, wr};
        mode_wr_data = {2'b00, d};
        conv_done    = {1'b0, dn};
        conv_alarm   = {1'b0, al};
        alarm_clr    = {1'b0, cl};
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc0(0, 2'b00, 0, 0, 0);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done_flag) begin
            done_flag = 1;
            total++; bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        cur_tag = "R1";
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        idle(3);

        cur_tag = "R2";
        cyc0(0, 0, 1, 1, 0); cyc0(0, 0, 1, 0, 0); idle(2);

        cur_tag = "R8";
        cyc0(0, 0, 0, 0, 1); idle(1);
        cyc0(0, 0, 1, 1, 1); idle(1);          // set beats clear
        cyc0(0, 0, 0, 0, 1); idle(2);

        cur_tag = "R3";
        cyc0(1, 2'b01, 0, 0, 0);
        cyc0(0, 0, 1, 1, 0); cyc0(0, 0, 1, 0, 0); idle(2);

        cur_tag = "R4";
        cyc0(1, 2'b10, 0, 0, 0); idle(1);
        cyc0(0, 0, 1, 1, 0); idle(2);
        cur_tag = "R5";
        cyc0(0, 0, 1, 0, 0); idle(2);

        cur_tag = "R9";
        cyc0(0, 0, 0, 1, 0); cyc0(0, 0, 0, 1, 0); idle(1);

        cur_tag = "R6";
        cyc0(1, 2'b11, 0, 0, 1); idle(1);
        cyc0(0, 0, 1, 1, 0); idle(1);
        cyc0(0, 0, 1, 0, 0); idle(2);

        cur_tag = "R7";
        cyc0(1, 2'b11, 0, 0, 0); idle(2);

        cur_tag = "R10";
        cyc0(1, 2'b11, 1, 1, 0); idle(1);       // write beats latch trip
        cyc0(1, 2'b10, 0, 0, 0);
        cyc0(1, 2'b10, 1, 1, 0); idle(1);       // write beats auto trip

        cur_tag = "R11";
        for (int v = 0; v < 4; v++) begin
            cyc0(1, 2'(v), 0, 0, 0); idle(1);
        end

        cur_tag = "R12";
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            mode_wr_en   = (($urandom % 8) == 0) ? NUM_CH'($urandom) : '0;
            mode_wr_data = (2*NUM_CH)'($urandom);
            conv_done    = NUM_CH'($urandom);
            conv_alarm   = NUM_CH'($urandom);
            alarm_clr    = (($urandom % 4) == 0) ? NUM_CH'($urandom) : '0;
        end
        idle(3);

        done_flag = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule